// File: doc/BRIEF.md
# Read-to-Acquire Lock Register Bank

This block guards one shared resource with a bank of lock registers, one register per requester. A requester tries to take the lock simply by reading its own register. The value returned is the busy bit as it stood before the read, and the read sets busy as a side effect. A returned 0 means the reader now owns the resource. A returned 1 means someone else owns it, and nothing changes. Writing the register gives the lock back.

All registers share a single busy flag and a single owner id, so at most one requester holds the resource at any time. Accesses arrive on one or more parallel access lanes. Each lane carries a read strobe, a write strobe and a byte address. The requester id is decoded from the address: the register of requester k sits at `BASE_ADDR + k*STRIDE`. When several reads meet a free lock in the same cycle, the lowest requester id wins. A release from any register other than the owner's is ignored. Software retry and back-off live outside the block.

Top module: `hwsem_bank`

## Requirements
- R1: After reset the lock is free: `lock_held` is 0, `lock_owner` is 0 and no lane shows `rd_valid`.
- R2: A read of register k while the lock is free returns bit 0 = 0 on that lane one cycle later. At that same edge `lock_held` becomes 1 and `lock_owner` becomes k.
- R3: A read while the lock is held returns bit 0 = 1. `lock_held` and `lock_owner` stay unchanged.
- R4: A write to the owner's register while the lock is held frees the lock at the next edge: `lock_held` becomes 0 and `lock_owner` becomes 0.
- R5: A write to any register other than the owner's has no effect on `lock_held` or `lock_owner`.
- R6: When reads from several lanes meet a free lock in one cycle, the lowest requester id is granted. If two lanes carry the same id, the lower lane is granted. Every other reading lane returns bit 0 = 1.
- R7: Register k is decoded only at byte address `BASE_ADDR + k*STRIDE` with 0 <= k < NUM_REQ. Any other address (misaligned, below the base or above the top) has no effect and produces no `rd_valid`.
- R8: A lane with read and write both asserted in one cycle performs only the read. Its write is dropped.
- R9: `rd_valid` of a lane rises exactly one cycle after a decoded read on that lane. In the read data, bit 0 carries the busy result and bits DATA_W-1:1 are always 0.
- R10: A read on one lane in the same cycle as the owner's release on another lane sees the old busy state and returns 1. The lock ends that cycle free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_rd | input | NUM_LANES | Read strobe per lane (acquire attempt) |
| acc_wr | input | NUM_LANES | Write strobe per lane (release) |
| acc_addr | input | NUM_LANES*ADDR_W | Byte address per lane, lane 0 in the low bits |
| rd_data | output | NUM_LANES*DATA_W | Read result per lane; bit 0 is the previous busy state |
| rd_valid | output | NUM_LANES | Read result valid, one cycle after a decoded read |
| lock_held | output | 1 | Shared busy flag |
| lock_owner | output | $clog2(NUM_REQ) | Requester id holding the lock, 0 when free |

## Verification
The assertions assume the strobes and addresses are known, non-X values at every rising edge once reset is released. They also assume the strobes are low while reset is asserted, because the response check compares against the decoded read one cycle back. The bench drives every input on the falling edge, holds all strobes at zero through reset, and keeps the random addresses mostly on decoded registers with some misaligned and out-of-range values mixed in. This way the contention, release and decode cases stay inside those assumptions.

// File: rtl/hwsem_pkg.sv
package hwsem_pkg;

  // True when a byte address lands exactly on one requester register.
  function automatic logic reg_hit(input logic [31:0] addr,
                                   input logic [31:0] base,
                                   input logic [31:0] stride,
                                   input logic [31:0] count);
    logic [31:0] off;
    off = addr - base;
    return (addr >= base) && (off < count * stride) && ((off % stride) == 32'd0);
  endfunction

  // Requester index addressed by a byte address (valid only on a hit).
  function automatic logic [31:0] reg_index(input logic [31:0] addr,
                                            input logic [31:0] base,
                                            input logic [31:0] stride);
    return (addr - base) / stride;
  endfunction

  // Read response word: only bit 0 carries information.
  function automatic logic [63:0] resp_word(input logic was_busy);
    return {63'd0, was_busy};
  endfunction

endpackage

// File: rtl/hwsem_decode.sv
module hwsem_decode #(
  parameter int NUM_REQ   = 8,
  parameter int ADDR_W    = 12,
  parameter int BASE_ADDR = 'h100,
  parameter int STRIDE    = 4,
  parameter int IW        = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  import hwsem_pkg::*;

  logic [31:0] addr_ext;
  logic [31:0] idx_full;

  assign addr_ext = 32'(addr);
  assign hit      = reg_hit(addr_ext, 32'(BASE_ADDR), 32'(STRIDE), 32'(NUM_REQ));
  assign idx_full = reg_index(addr_ext, 32'(BASE_ADDR), 32'(STRIDE));
  assign idx      = hit ? idx_full[IW-1:0] : '0;

endmodule

// File: rtl/hwsem_arbiter.sv
module hwsem_arbiter #(
  parameter int NUM_LANES = 2,
  parameter int IW        = 3
) (
  input  logic [NUM_LANES-1:0]    cand,
  input  logic [NUM_LANES*IW-1:0] cand_idx,
  input  logic                    lock_busy,
  output logic [NUM_LANES-1:0]    grant,
  output logic [IW-1:0]           win_idx,
  output logic                    acquire
);
  localparam int LW = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;

  logic          found;
  logic [IW-1:0] best_idx;
  logic [LW-1:0] best_lane;

  // Lowest requester id wins; strict compare keeps the lower lane on a tie.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_lane = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      if (cand[l] && (!found || (cand_idx[l*IW +: IW] < best_idx))) begin
        found     = 1'b1;
        best_idx  = cand_idx[l*IW +: IW];
        best_lane = LW'(l);
      end
    end
  end

  assign acquire = found && !lock_busy;
  assign win_idx = best_idx;

  always_comb begin
    grant = '0;
    if (acquire) grant[best_lane] = 1'b1;
  end

endmodule

// File: rtl/hwsem_lock_state.sv
module hwsem_lock_state #(
  parameter int NUM_LANES = 2,
  parameter int IW        = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acquire,
  input  logic [IW-1:0]           win_idx,
  input  logic [NUM_LANES-1:0]    wr_eff,
  input  logic [NUM_LANES*IW-1:0] lane_idx,
  output logic                    busy,
  output logic [IW-1:0]           owner,
  output logic                    release_ev
);
  logic [NUM_LANES-1:0] owner_match;

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_match
      assign owner_match[l] = wr_eff[l] && (lane_idx[l*IW +: IW] == owner);
    end
  endgenerate

  assign release_ev = busy && (|owner_match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (acquire) begin
      busy  <= 1'b1;
      owner <= win_idx;
    end else if (release_ev) begin
      busy  <= 1'b0;
      owner <= '0;
    end
  end

endmodule

// File: rtl/hwsem_bank.sv
module hwsem_bank #(
  parameter int NUM_REQ   = 8,
  parameter int NUM_LANES = 2,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int BASE_ADDR = 'h100,
  parameter int STRIDE    = 4,
  localparam int IW       = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LANES-1:0]        acc_rd,
  input  logic [NUM_LANES-1:0]        acc_wr,
  input  logic [NUM_LANES*ADDR_W-1:0] acc_addr,
  output logic [NUM_LANES*DATA_W-1:0] rd_data,
  output logic [NUM_LANES-1:0]        rd_valid,
  output logic                        lock_held,
  output logic [IW-1:0]               lock_owner
);
  import hwsem_pkg::*;

  // Named internal events, visible to the bound checker.
  logic [NUM_LANES-1:0]    lane_hit;
  logic [NUM_LANES*IW-1:0] lane_idx;
  logic [NUM_LANES-1:0]    rd_eff;
  logic [NUM_LANES-1:0]    wr_eff;
  logic [NUM_LANES-1:0]    grant;
  logic [IW-1:0]           win_idx;
  logic                    acquire;
  logic                    release_ev;
  logic                    busy;
  logic [IW-1:0]           owner;

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      hwsem_decode #(
        .NUM_REQ  (NUM_REQ),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR),
        .STRIDE   (STRIDE),
        .IW       (IW)
      ) u_dec (
        .addr(acc_addr[l*ADDR_W +: ADDR_W]),
        .hit (lane_hit[l]),
        .idx (lane_idx[l*IW +: IW])
      );
    end
  endgenerate

  // A read on a lane shadows a write on the same lane.
  assign rd_eff = acc_rd & lane_hit;
  assign wr_eff = acc_wr & ~acc_rd & lane_hit;

  hwsem_arbiter #(
    .NUM_LANES(NUM_LANES),
    .IW       (IW)
  ) u_arb (
    .cand     (rd_eff),
    .cand_idx (lane_idx),
    .lock_busy(busy),
    .grant    (grant),
    .win_idx  (win_idx),
    .acquire  (acquire)
  );

  hwsem_lock_state #(
    .NUM_LANES(NUM_LANES),
    .IW       (IW)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .acquire   (acquire),
    .win_idx   (win_idx),
    .wr_eff    (wr_eff),
    .lane_idx  (lane_idx),
    .busy      (busy),
    .owner     (owner),
    .release_ev(release_ev)
  );

  // Read responses: the granted lane sees "was free", all others "was busy".
  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_resp
      logic [63:0] word;
      assign word = resp_word(busy || !grant[l]);
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rd_valid[l]              <= 1'b0;
          rd_data[l*DATA_W +: DATA_W] <= '0;
        end else begin
          rd_valid[l] <= rd_eff[l];
          if (rd_eff[l]) rd_data[l*DATA_W +: DATA_W] <= word[DATA_W-1:0];
        end
      end
    end
  endgenerate

  assign lock_held  = busy;
  assign lock_owner = owner;

endmodule

// File: rtl/hwsem_bank_chk.sv
module hwsem_bank_chk #(
  parameter int NUM_LANES = 2,
  parameter int DATA_W    = 32,
  parameter int IW        = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_LANES-1:0]        rd_eff,
  input logic [NUM_LANES-1:0]        grant,
  input logic                        acquire,
  input logic                        release_ev,
  input logic [IW-1:0]               win_idx,
  input logic [NUM_LANES*DATA_W-1:0] rd_data,
  input logic [NUM_LANES-1:0]        rd_valid,
  input logic                        lock_held,
  input logic [IW-1:0]               lock_owner
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  free_owner_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_held |-> (lock_owner == '0));

  // R2
  acquire_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acquire |=> (lock_held && (lock_owner == $past(win_idx))));

  // R3
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_held && !release_ev) |=> (lock_held && $stable(lock_owner)));

  // R4
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> !lock_held);

  // R6
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R3
  no_grant_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_held |-> (grant == '0));

  generate
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
      // R9
      resp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rd_valid[l] == $past(rd_eff[l])));
      // R9
      resp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid[l] |-> (rd_data[l*DATA_W+1 +: DATA_W-1] == '0));
      // R2
      granted_sees_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant[l] |=> (rd_valid[l] && !rd_data[l*DATA_W]));
    end
  endgenerate

endmodule

bind hwsem_bank hwsem_bank_chk #(
  .NUM_LANES(NUM_LANES),
  .DATA_W   (DATA_W),
  .IW       (IW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_eff    (rd_eff),
  .grant     (grant),
  .acquire   (acquire),
  .release_ev(release_ev),
  .win_idx   (win_idx),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .lock_held (lock_held),
  .lock_owner(lock_owner)
);

// File: tb/hwsem_bank_tb.sv
module hwsem_bank_tb_top;
  localparam int NREQ  = 8;
  localparam int NL    = 2;
  localparam int AW    = 12;
  localparam int DW    = 32;
  localparam int BASE  = 'h100;
  localparam int STR   = 4;
  localparam int IW    = 3;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [NL-1:0]       acc_rd = '0;
  logic [NL-1:0]       acc_wr = '0;
  logic [NL*AW-1:0]    acc_addr = '0;
  logic [NL*DW-1:0]    rd_data;
  logic [NL-1:0]       rd_valid;
  logic                lock_held;
  logic [IW-1:0]       lock_owner;

  always #2 clk = ~clk;

  hwsem_bank #(
    .NUM_REQ(NREQ), .NUM_LANES(NL), .ADDR_W(AW), .DATA_W(DW),
    .BASE_ADDR(BASE), .STRIDE(STR)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .lock_held(lock_held), .lock_owner(lock_owner)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Reference model state
  int m_busy = 0;
  int m_owner = 0;

  function automatic int addr_of(input int k);
    return BASE + k * STR;
  endfunction

  task automatic report(input bit bad, input string tag, input string what,
                        input int act, input int exp, inout bit any);
    if (bad) begin
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      any = 1'b1;
    end
  endtask

  // One clock: drive on falling edge, model, sample after the rising edge.
  task automatic step(input bit r0, input bit w0, input int a0,
                      input bit r1, input bit w1, input int a1,
                      input string tag);
    int a[NL]; bit r[NL]; bit w[NL];
    bit re[NL]; bit we[NL]; int id[NL]; int exp_d[NL];
    int win; int wid; bit any_bad;
    a[0] = a0; a[1] = a1; r[0] = r0; r[1] = r1; w[0] = w0; w[1] = w1;
    @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      acc_rd[l] = r[l];
      acc_wr[l] = w[l];
      acc_addr[l*AW +: AW] = AW'(a[l]);
      re[l] = 1'b0; we[l] = 1'b0; id[l] = 0;
      if (a[l] >= BASE && a[l] < BASE + NREQ*STR && ((a[l]-BASE) % STR) == 0) begin
        id[l] = (a[l]-BASE) / STR;
        re[l] = r[l];
        we[l] = w[l] && !r[l];
      end
    end
    win = -1; wid = 0;
    for (int l = 0; l < NL; l++)
      if (re[l] && (win < 0 || id[l] < wid)) begin win = l; wid = id[l]; end
    for (int l = 0; l < NL; l++)
      exp_d[l] = (m_busy != 0) ? 1 : ((l == win) ? 0 : 1);
    if (m_busy == 0 && win >= 0) begin
      m_busy = 1; m_owner = wid;
    end else if (m_busy != 0) begin
      bit rel = 1'b0;
      for (int l = 0; l < NL; l++) if (we[l] && id[l] == m_owner) rel = 1'b1;
      if (rel) begin m_busy = 0; m_owner = 0; end
    end
    @(posedge clk);
    #1;
    any_bad = 1'b0;
    vectors++;
    report(lock_held !== 1'(m_busy), tag, "lock_held", int'(lock_held), m_busy, any_bad);
    report(int'(lock_owner) != m_owner, tag, "lock_owner", int'(lock_owner), m_owner, any_bad);
    for (int l = 0; l < NL; l++) begin
      report(rd_valid[l] !== re[l], tag, $sformatf("rd_valid[%0d]", l),
             int'(rd_valid[l]), int'(re[l]), any_bad);
      if (re[l])
        report(rd_data[l*DW +: DW] !== DW'(exp_d[l]), tag,
               $sformatf("rd_data[%0d]", l), int'(rd_data[l*DW +: DW]), exp_d[l], any_bad);
    end
    if (any_bad) miscompares++;
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, no activity
    idle("R1");
    idle("R1");
    // R2: acquire requester 3 on lane 0
    step(1, 0, addr_of(3), 0, 0, 0, "R2");
    // R3: requester 5 reads while held
    step(0, 0, 0, 1, 0, addr_of(5), "R3");
    step(1, 0, addr_of(3), 0, 0, 0, "R3");
    // R5: non-owner release ignored
    step(0, 1, addr_of(5), 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, addr_of(0), "R5");
    // R4: owner releases
    step(0, 0, 0, 0, 1, addr_of(3), "R4");
    idle("R4");
    // R6: contention, lower id on lane 1 wins
    step(1, 0, addr_of(6), 1, 0, addr_of(2), "R6");
    step(0, 1, addr_of(2), 0, 0, 0, "R4");
    // R6: same register on both lanes, lane 0 wins
    step(1, 0, addr_of(1), 1, 0, addr_of(1), "R6");
    step(0, 1, addr_of(1), 0, 0, 0, "R4");
    // R7: misaligned, below, above the register window
    step(1, 0, BASE + 2, 1, 0, BASE + NREQ*STR, "R7");
    step(1, 0, BASE - STR, 0, 1, BASE + 1, "R7");
    // R7: first and last register
    step(1, 0, addr_of(0), 0, 0, 0, "R7");
    step(0, 1, addr_of(0), 1, 0, addr_of(NREQ-1), "R7");
    step(0, 0, 0, 1, 0, addr_of(NREQ-1), "R7");
    // R8: read+write on same lane from owner: read only, lock stays
    step(1, 1, addr_of(NREQ-1), 0, 0, 0, "R8");
    // R10: release and read meet in one cycle
    step(1, 0, addr_of(4), 0, 1, addr_of(NREQ-1), "R10");
    step(1, 0, addr_of(4), 0, 0, 0, "R10");
    step(0, 1, addr_of(4), 0, 0, 0, "R4");
    // R9: back-to-back reads, response one cycle later, upper bits zero
    step(1, 0, addr_of(2), 1, 0, addr_of(5), "R9");
    step(1, 0, addr_of(2), 1, 0, addr_of(5), "R9");
    step(0, 1, addr_of(2), 0, 0, 0, "R9");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int a0; int a1;
      a0 = ($urandom % 8 == 0) ? BASE + int'($urandom % 48) : addr_of(int'($urandom % NREQ));
      a1 = ($urandom % 8 == 0) ? BASE + int'($urandom % 48) : addr_of(int'($urandom % NREQ));
      step(1'($urandom), 1'($urandom), a0, 1'($urandom), 1'($urandom), a1, "R6");
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      $display("FAIL watchdog: got running expected finished");
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule